// File: doc/BRIEF.md
# Serial Byte Transmitter with Line-Break Override

This block turns bytes written by software or by a DMA engine into asynchronous serial frames on a single output pin. A one-byte holding register feeds a shift register. A status flag shows when the holding register is free. Software first reads that flag as 1, then writes a byte, then writes 0 to the flag to hand the byte over. A DMA engine does the same in one strobe. A request output stays asserted while the holding register is free, so it can drive an interrupt or a DMA channel. A second flag reports that the line has gone quiet after the last frame.

When the transmitter is disabled, a small port register can take over the pin. Setting the port to drive a low level and then clearing the enable produces a break. There is no valid/ready stream at the edge. The free flag is the only back-pressure: while it reads 0, byte writes from the bus and from DMA are dropped.

Top module: `uart_tx_brk`

## Requirements
- R1: After reset, status (address 1) reads 3 (bit 0 free flag = 1, bit 1 line-quiet flag = 1), control reads 0, port reads 1 (level 1, drive 0), the pin is high and the request is low.
- R2: A bus write to address 0 loads the holding register only while the free flag is 1. Otherwise it is ignored, and a read of address 0 returns the held byte.
- R3: A bus write to address 1 with bit 0 = 0 clears the free flag only if the transmitter is enabled and the status was read while the flag was 1, with no clear since. Without that read, the write has no effect.
- R4: The request output is high exactly when the transmitter is enabled and the free flag is 1.
- R5: A DMA strobe while enabled and free loads the holding register and clears the free flag in the same edge. A DMA strobe while the flag is 0 is ignored.
- R6: A handed-over byte is copied to the shift register once it is idle, and the free flag returns to 1 in that edge. The frame is a 0 start bit, 8 data bits LSB first, then a 1 stop bit, each lasting 16 baud ticks.
- R7: The line-quiet flag is cleared when a byte is handed over. It is set when a stop bit ends while the free flag is 1.
- R8: While enabled and not sending, the pin is high.
- R9: While the transmitter is disabled, the pin equals port bit 0 if port bit 1 (drive) is 1, and is high otherwise.
- R10: Clearing the enable (control bit 0) aborts any frame at once and sets both status flags to 1.
- R11: Control bit 0 and port bits 1:0 read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit time |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the clear handshake) |
| bus_addr | input | 2 | 0 data, 1 status, 2 control, 3 port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| dma_wr | input | 1 | DMA write strobe to the holding register |
| dma_wdata | input | 8 | DMA write data |
| tx_req | output | 1 | Holding register free request |
| tx_pin | output | 1 | Serial output |

## Verification
The bench goes after the handshake edges. It tries a clear of the free flag without the arming read, which a design lacking the arm would accept, sending a stale byte. It also writes bytes while the register is full, which a design without the gate would let overwrite the queued byte. DMA strobes are sent back-to-back while a frame is on the line, to show that only the first one that finds the register free is taken. An enable drop in mid-frame, with the port set to drive low, must turn the pin low on the next cycle. A design that let the frame run out, or left the flags at 0, would show up at once in the per-cycle comparison.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    A_DATA = 2'd0,
    A_STAT = 2'd1,
    A_CTRL = 2'd2,
    A_PORT = 2'd3
  } reg_addr_e;

  localparam int STAT_FREE_BIT  = 0;
  localparam int STAT_QUIET_BIT = 1;
  localparam int CTRL_EN_BIT    = 0;
  localparam int PORT_LVL_BIT   = 0;
  localparam int PORT_DRV_BIT   = 1;
endpackage

// File: rtl/uart_tx_regs.sv
module uart_tx_regs
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic              take,
  input  logic              frame_done,
  output logic              ten,
  output logic [DATA_W-1:0] hold,
  output logic              hold_full,
  output logic              port_lvl,
  output logic              port_drv,
  output logic              tx_req
);
  logic empty, quiet, armed;
  logic commit_cpu, commit_dma, commit;

  assign commit_cpu = ten && empty && armed && bus_wr && (bus_addr == A_STAT)
                      && !bus_wdata[STAT_FREE_BIT];
  assign commit_dma = ten && empty && dma_wr;
  assign commit     = commit_cpu || commit_dma;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ten      <= 1'b0;
      empty    <= 1'b1;
      quiet    <= 1'b1;
      armed    <= 1'b0;
      hold     <= '0;
      port_lvl <= 1'b1;
      port_drv <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == A_CTRL) ten <= bus_wdata[CTRL_EN_BIT];
      if (bus_wr && bus_addr == A_PORT) begin
        port_lvl <= bus_wdata[PORT_LVL_BIT];
        port_drv <= bus_wdata[PORT_DRV_BIT];
      end
      if (commit_dma)                                 hold <= dma_wdata;
      else if (bus_wr && bus_addr == A_DATA && empty) hold <= bus_wdata;

      if (!ten) begin
        empty <= 1'b1;
        quiet <= 1'b1;
        armed <= 1'b0;
      end else if (take) begin
        empty <= 1'b1;
        armed <= 1'b0;
      end else if (commit) begin
        empty <= 1'b0;
        quiet <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (bus_rd && bus_addr == A_STAT && empty) armed <= 1'b1;
        if (frame_done && empty)                   quiet <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_DATA: bus_rdata = hold;
      A_STAT: begin
        bus_rdata[STAT_FREE_BIT]  = empty;
        bus_rdata[STAT_QUIET_BIT] = quiet;
      end
      A_CTRL: bus_rdata[CTRL_EN_BIT] = ten;
      default: begin
        bus_rdata[PORT_LVL_BIT] = port_lvl;
        bus_rdata[PORT_DRV_BIT] = port_drv;
      end
    endcase
  end

  assign hold_full = !empty;
  assign tx_req    = empty && ten;

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA && !empty) |=> $stable(hold)); // R2
  AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> empty); // R6
  AST_OFF_FLAGS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |=> (empty && quiet)); // R10
  AST_HANDOVER_CLEARS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> !quiet); // R7
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ten,
  input  logic              baud_tick,
  input  logic              hold_full,
  input  logic [DATA_W-1:0] hold,
  output logic              take,
  output logic              frame_done,
  output logic              busy,
  output logic              ser_bit
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int POS_W   = $clog2(FRAME_W);
  localparam int TICK_W  = $clog2(OVERSAMPLE);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_W - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OVERSAMPLE - 1);

  logic [FRAME_W-1:0] sh;
  logic [POS_W-1:0]   pos;
  logic [TICK_W-1:0]  ticks;
  logic               bit_end;

  assign take       = ten && !busy && hold_full;
  assign bit_end    = busy && baud_tick && (ticks == LAST_TICK);
  assign frame_done = bit_end && (pos == LAST_POS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '1;
      pos   <= '0;
      ticks <= '0;
      busy  <= 1'b0;
    end else if (!ten) begin
      pos   <= '0;
      ticks <= '0;
      busy  <= 1'b0;
    end else if (take) begin
      sh    <= {1'b1, hold, 1'b0};
      pos   <= '0;
      ticks <= '0;
      busy  <= 1'b1;
    end else if (busy && baud_tick) begin
      if (bit_end) begin
        ticks <= '0;
        if (pos == LAST_POS) begin
          busy <= 1'b0;
        end else begin
          pos <= pos + 1'b1;
          sh  <= {1'b1, sh[FRAME_W-1:1]};
        end
      end else begin
        ticks <= ticks + 1'b1;
      end
    end
  end

  assign ser_bit = sh[0];

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy); // R7
endmodule

// File: rtl/uart_tx_pin.sv
module uart_tx_pin (
  input  logic ten,
  input  logic busy,
  input  logic ser_bit,
  input  logic port_lvl,
  input  logic port_drv,
  output logic tx_pin
);
  always_comb begin
    if (ten)           tx_pin = busy ? ser_bit : 1'b1;
    else if (port_drv) tx_pin = port_lvl;
    else               tx_pin = 1'b1;
  end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              tx_req,
  output logic              tx_pin
);
  logic              ten, hold_full, port_lvl, port_drv;
  logic              take, frame_done, busy, ser_bit;
  logic [DATA_W-1:0] hold;

  uart_tx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .take(take),
    .frame_done(frame_done), .ten(ten), .hold(hold), .hold_full(hold_full),
    .port_lvl(port_lvl), .port_drv(port_drv), .tx_req(tx_req)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk(clk), .rst_n(rst_n), .ten(ten), .baud_tick(baud_tick),
    .hold_full(hold_full), .hold(hold), .take(take),
    .frame_done(frame_done), .busy(busy), .ser_bit(ser_bit)
  );

  uart_tx_pin u_pin (
    .ten(ten), .busy(busy), .ser_bit(ser_bit),
    .port_lvl(port_lvl), .port_drv(port_drv), .tx_pin(tx_pin)
  );

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && $rose(busy)) |-> !tx_pin); // R6
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && !busy) |-> tx_pin); // R8
  AST_BREAK_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ten) && port_drv && $stable(port_drv) && $stable(port_lvl)) |-> (tx_pin == port_lvl)); // R9
endmodule

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       b_tick = 1'b0;
  logic       b_wr = 1'b0, b_rd = 1'b0, d_wr = 1'b0;
  logic [1:0] b_addr = 2'd0;
  logic [7:0] b_wdata = 8'd0, d_wdata = 8'd0;
  logic [7:0] b_rdata;
  logic       tx_req, tx_pin;

  int n_checks = 0, n_fail = 0, tcnt = 0;
  bit finished = 0;

  // reference model state
  int m_ten, m_free, m_quiet, m_armed, m_hold, m_lvl, m_drv;
  int m_busy, m_pos, m_tk, m_byte;

  always #2.5 clk = ~clk;

  uart_tx_brk u_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .baud_tick(b_tick), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
    .dma_wr(d_wr), .dma_wdata(d_wdata), .tx_req(tx_req), .tx_pin(tx_pin)
  );

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 3;
    b_tick = (tcnt == 0);
  end

  function automatic int exp_pin();
    if (m_ten != 0) begin
      if (m_busy == 0) return 1;
      if (m_pos == 0) return 0;
      if (m_pos == 9) return 1;
      return (m_byte >> (m_pos - 1)) & 1;
    end
    return (m_drv != 0) ? m_lvl : 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ten = 0; m_free = 1; m_quiet = 1; m_armed = 0; m_hold = 0;
      m_lvl = 1; m_drv = 0; m_busy = 0; m_pos = 0; m_tk = 0; m_byte = 0;
    end else begin
      int done, take, cpu_clr, dma_ok, old_hold;
      done    = (m_busy != 0 && b_tick && m_tk == 15 && m_pos == 9);
      take    = (m_ten != 0 && m_busy == 0 && m_free == 0);
      cpu_clr = (m_ten != 0 && m_free != 0 && m_armed != 0 && b_wr && b_addr == 2'd1 && !b_wdata[0]);
      dma_ok  = (m_ten != 0 && m_free != 0 && d_wr);
      old_hold = m_hold;
      if (m_ten == 0) begin
        m_busy = 0; m_pos = 0; m_tk = 0;
      end else if (take) begin
        m_busy = 1; m_pos = 0; m_tk = 0; m_byte = old_hold;
      end else if (m_busy != 0 && b_tick) begin
        if (m_tk == 15) begin
          m_tk = 0;
          if (m_pos == 9) m_busy = 0; else m_pos++;
        end else m_tk++;
      end
      if (dma_ok) m_hold = d_wdata;
      else if (b_wr && b_addr == 2'd0 && m_free != 0) m_hold = b_wdata;
      if (m_ten == 0) begin
        m_free = 1; m_quiet = 1; m_armed = 0;
      end else if (take) begin
        m_free = 1; m_armed = 0;
      end else if (cpu_clr || dma_ok) begin
        m_free = 0; m_quiet = 0; m_armed = 0;
      end else begin
        if (b_rd && b_addr == 2'd1 && m_free != 0) m_armed = 1;
        if (done && m_free != 0) m_quiet = 1;
      end
      if (b_wr && b_addr == 2'd2) m_ten = b_wdata[0];
      if (b_wr && b_addr == 2'd3) begin m_lvl = b_wdata[0]; m_drv = b_wdata[1]; end
    end
    #1;
    if (rst_n && !finished) begin
      string ptag;
      ptag = (m_ten == 0) ? "R9 pin" : ((m_busy != 0) ? "R6 pin" : "R8 pin");
      check(ptag, tx_pin, exp_pin());
      check("R4 req", tx_req, (m_ten != 0 && m_free != 0) ? 1 : 0);
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk); b_wr = 0;
  endtask

  task automatic dma(logic [7:0] d);
    @(negedge clk); d_wr = 1; d_wdata = d;
    @(negedge clk); d_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, int exp, string tag);
    @(negedge clk); b_rd = 1; b_addr = a; #1;
    check(tag, b_rdata, exp);
    @(negedge clk); b_rd = 0;
  endtask

  task automatic rd_stat(string tag);
    @(negedge clk); b_rd = 1; b_addr = 2'd1; #1;
    check(tag, b_rdata, m_quiet * 2 + m_free);
    @(negedge clk); b_rd = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (m_busy == 0 && m_free != 0) break;
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd1, 3, "R1 status");
    rd(2'd2, 0, "R1 control");
    rd(2'd3, 1, "R1 port");
    check("R1 pin", tx_pin, 1);
    check("R1 req", tx_req, 0);
    // R9 port override while disabled, R11 readback
    wr(2'd3, 8'h02);
    @(negedge clk); check("R9 break low", tx_pin, 0);
    rd(2'd3, 2, "R11 port");
    wr(2'd3, 8'h00);
    @(negedge clk); check("R9 undriven high", tx_pin, 1);
    // enable, R8 idle
    wr(2'd2, 8'h01);
    rd(2'd2, 1, "R11 control");
    @(negedge clk); check("R8 idle", tx_pin, 1);
    // R2 write while free, R3 clear without arm ignored
    wr(2'd0, 8'hA5);
    rd(2'd0, 8'hA5, "R2 load");
    wr(2'd1, 8'h00);
    rd_stat("R3 unarmed clear ignored");
    check("R3 still free", m_free, 1);
    // arm then clear: frame goes out
    rd_stat("R3 arm read");
    wr(2'd1, 8'h00);
    repeat (3) @(negedge clk);
    wait_idle();
    repeat (2) @(negedge clk);
    rd(2'd1, 3, "R7 quiet after stop");
    // back-to-back, and R2 write while full dropped
    wr(2'd0, 8'h3C); rd_stat("R3 arm 2"); wr(2'd1, 8'h00);
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h81); rd_stat("R3 arm 3"); wr(2'd1, 8'h00);
    rd(2'd1, 0, "R7 queued cleared");
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h81, "R2 full write dropped");
    wait_idle();
    repeat (2) @(negedge clk);
    rd(2'd1, 3, "R7 quiet after pair");
    // R5 DMA
    dma(8'h5A);
    repeat (2) @(negedge clk);
    dma(8'h11);
    rd(2'd1, 0, "R5 dma clears free");
    dma(8'h22);
    rd(2'd0, 8'h11, "R5 dma while full ignored");
    wait_idle();
    repeat (2) @(negedge clk);
    // R10 abort mid-frame into break
    wr(2'd0, 8'h00); rd_stat("R3 arm 4"); wr(2'd1, 8'h00);
    repeat (100) @(negedge clk);
    wr(2'd3, 8'h02);
    wr(2'd2, 8'h00);
    check("R9 break after disable", tx_pin, 0);
    rd(2'd1, 3, "R10 flags set on abort");
    wr(2'd3, 8'h01);
    @(negedge clk); check("R9 release", tx_pin, 1);
    repeat (5) @(negedge clk);
    summary();
  end
endmodule